// File: doc/BRIEF.md
# Calendar Real-Time Clock Core

This core keeps wall-clock time and a calendar: seconds, minutes, hours, day of week, day of month, month, two-digit year and century. A pulse input at the reference-oscillator rate is divided down inside the core to a once-per-second step. Software reads and writes every field, and a mode register, through a small register port with a 4-bit address. Reads are combinational. Writes take effect on the clock edge.

All counters are held internally as plain binary on a 24-hour clock. The register port translates on the fly. It presents and accepts either packed BCD or binary, and in 12-hour format it uses a PM flag in bit 7 of the hour byte. Because of this, software can switch encoding or hour format at any moment without touching stored time. The core also applies the two yearly daylight-saving shifts on two dates set by parameters. It compares the time against an alarm setting and exports a one-cycle match pulse for a power-control block. It raises a sticky interrupt whose active level software selects.

Register map (address: content): 0 seconds, 1 minutes, 2 hours, 3 day of week (1..7), 4 day of month, 5 month, 6 year (0..99), 7 century, 8 alarm seconds, 9 alarm minutes, 10 alarm hours, 11 alarm day of month, 12 mode. Mode bits: bit 0 = 1 selects binary and 0 selects BCD; bit 1 = 1 selects 12-hour format; bit 2 enables daylight saving; bit 3 freezes the counters; bit 4 = 1 makes the interrupt active high; writing 1 to bit 7 clears the pending alarm and is not stored (bits 7..5 read 0).

Top module: `rtc_core`

## Requirements
- R1: After reset the time is 00:00:00 on day 1 of month 1, day of week 1, year 0, century 20. The mode is 0, so the core uses BCD and 24-hour format. Seconds advance by one for every PRESCALE pulses on `ref_tick`.
- R2: With mode bit 0 clear, every field is read and written as packed BCD (tens in bits 7..4). With bit 0 set, fields are plain binary. Changing bit 0 does not alter the stored time.
- R3: With mode bit 1 set, the hour byte carries PM in bit 7 and the hours 12, 1..11 in bits 6..0. Midnight reads as 12 with PM clear, and 11:59:59 AM steps to 12 with PM set.
- R4: Seconds carry into minutes, minutes into hours, and 23:59:59 rolls to 00:00:00. The roll advances the day of month and the day of week, and the day of week wraps from 7 to 1.
- R5: Months 4, 6, 9 and 11 have 30 days, and February has 28 days, or 29 when the year is divisible by 4. For year 0 the century must also be divisible by 4.
- R6: Day 31 of month 12 rolls to day 1 of month 1 and advances the year. Year 99 wraps to 0 and advances the century.
- R7: With mode bit 2 set, at 01:59:59 on the spring date (parameters, default month 3 day 10) the next second is 03:00:00. With bit 2 clear it is 02:00:00.
- R8: With mode bit 2 set, at 01:59:59 on the autumn date (default month 11 day 3) the next second is 01:00:00. This happens only once per day, so the next pass of 01:59:59 that day goes to 02:00:00.
- R9: While mode bit 3 is set, seconds do not advance, but fields can still be written. After the bit is cleared, counting resumes at the next one-second step.
- R10: A field written with a value at or above its maximum (seconds ≥59, minutes ≥59, hours ≥23, month ≥12, year ≥99, day ≥ month length) wraps to its minimum at the next step and carries into the next field.
- R11: When a one-second step lands on the alarm seconds, minutes, hours and day of month, `alarm_match_o` is high for exactly one cycle. The alarm day resets to 0, which never matches.
- R12: A match sets a pending flag that stays set until mode is written with bit 7 set. `irq_o` equals the flag when mode bit 4 is 1, and its inverse otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference oscillator period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data, in current encoding |
| rdata | output | 8 | Read data for `addr`, in current encoding |
| alarm_match_o | output | 1 | One-cycle pulse on alarm match |
| irq_o | output | 1 | Alarm interrupt, polarity from mode bit 4 |

## Verification
The embedded assertions check several rules on every cycle. The divided step is never two cycles wide. A second below 58 steps by exactly one. A step that does not wrap minutes leaves hour and date untouched. A step with the freeze bit set changes nothing. The spring shift always lands on hour 3. A match always sets the pending flag, and the flag never drops without a clear. The directed scenarios show what only a whole sequence reveals: month lengths and the century leap rule, the year and century carry, the BCD and 12-hour translation at the register port, the one-time autumn repeat, wrap from illegal written values, and the interrupt level under both polarities.

// File: rtl/rtc_pkg.sv
// Shared types, register addresses and calendar helper functions for the
// calendar real-time clock. All stored values are binary, 24-hour.
package rtc_pkg;

    localparam logic [3:0] ADDR_SEC   = 4'h0;
    localparam logic [3:0] ADDR_MIN   = 4'h1;
    localparam logic [3:0] ADDR_HOUR  = 4'h2;
    localparam logic [3:0] ADDR_DOW   = 4'h3;
    localparam logic [3:0] ADDR_DOM   = 4'h4;
    localparam logic [3:0] ADDR_MON   = 4'h5;
    localparam logic [3:0] ADDR_YEAR  = 4'h6;
    localparam logic [3:0] ADDR_CENT  = 4'h7;
    localparam logic [3:0] ADDR_ASEC  = 4'h8;
    localparam logic [3:0] ADDR_AMIN  = 4'h9;
    localparam logic [3:0] ADDR_AHOUR = 4'hA;
    localparam logic [3:0] ADDR_ADOM  = 4'hB;
    localparam logic [3:0] ADDR_MODE  = 4'hC;

    localparam int MODE_W = 5;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] dom;
        logic [7:0] mon;
        logic [7:0] year;
        logic [7:0] cent;
    } cal_t;

    // Binary to packed BCD; values above 99 wrap in the tens digit.
    function automatic logic [7:0] bcd_of(input logic [7:0] v);
        logic [7:0] t, o;
        t = v / 8'd10;
        o = v % 8'd10;
        return {t[3:0], o[3:0]};
    endfunction

    // Packed BCD to binary; illegal digits give a defined 8-bit result.
    function automatic logic [7:0] bin_of(input logic [7:0] b);
        return ({4'd0, b[7:4]} * 8'd10) + {4'd0, b[3:0]};
    endfunction

    // Leap test: year divisible by 4, year 0 also needs century divisible by 4.
    function automatic logic is_leap(input logic [7:0] yr, input logic [7:0] cent);
        return (yr[1:0] == 2'b00) && ((yr != 8'd0) || (cent[1:0] == 2'b00));
    endfunction

    // Last day of a month; unknown month numbers count as 31-day months.
    function automatic logic [7:0] month_days(input logic [7:0] mon, input logic leap);
        case (mon)
            8'd2:                    return leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
            default:                 return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Divides a reference pulse stream by PRESCALE into a one-cycle step pulse.
// Assumes ref_tick is a single-cycle strobe; the step appears one cycle after
// the PRESCALE-th reference pulse.
module rtc_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    output logic tick_o
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_q;

    // Count reference pulses and emit a step on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= 1'b0;
            if (ref_tick) begin
                if (cnt_q == LAST) begin
                    cnt_q  <= '0;
                    tick_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    generate
        if (PRESCALE > 1) begin : g_chk
            // R1: a divided step is never wider than one cycle
            a_r1_step_single: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/rtc_calendar.sv
// Time and calendar counter chain, binary 24-hour internally. Applies carries,
// month lengths, leap years, century roll and the two daylight-saving shifts.
// Assumes a register write in the same cycle as a step drops that step.
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int FWD_MON  = 3,
    parameter int FWD_DAY  = 10,
    parameter int BACK_MON = 11,
    parameter int BACK_DAY = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       hold_i,
    input  logic       dst_en_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_sel_i,
    input  logic [7:0] wr_val_i,
    output cal_t       cal_o,
    output logic       stepped_o
);
    localparam logic [7:0] FWD_M  = 8'(FWD_MON);
    localparam logic [7:0] FWD_D  = 8'(FWD_DAY);
    localparam logic [7:0] BACK_M = 8'(BACK_MON);
    localparam logic [7:0] BACK_D = 8'(BACK_DAY);

    cal_t cal_q, nxt;
    logic fell_q;
    logic advance;
    logic c_sec, c_min, c_hour, c_day, c_mon, c_year;
    logic jump_fwd, repeat_hr;
    logic [7:0] dim;

    assign advance = tick_i && !hold_i && !wr_en_i;
    assign cal_o   = cal_q;

    // Carry terms; >= gives defined wrap from out-of-range written values.
    always_comb begin
        dim       = month_days(cal_q.mon, is_leap(cal_q.year, cal_q.cent));
        c_sec     = cal_q.sec >= 8'd59;
        c_min     = c_sec && (cal_q.min >= 8'd59);
        c_hour    = c_min && (cal_q.hour >= 8'd23);
        c_day     = c_hour && (cal_q.dom >= dim);
        c_mon     = c_day && (cal_q.mon >= 8'd12);
        c_year    = c_mon && (cal_q.year >= 8'd99);
        jump_fwd  = dst_en_i && (cal_q.mon == FWD_M) && (cal_q.dom == FWD_D)
                    && (cal_q.hour == 8'd1);
        repeat_hr = dst_en_i && (cal_q.mon == BACK_M) && (cal_q.dom == BACK_D)
                    && (cal_q.hour == 8'd1) && !fell_q;
    end

    // Next-state of every field for one step.
    always_comb begin
        nxt     = cal_q;
        nxt.sec = c_sec ? 8'd0 : cal_q.sec + 8'd1;
        if (c_sec)  nxt.min = c_min ? 8'd0 : cal_q.min + 8'd1;
        if (c_min) begin
            if (c_hour)         nxt.hour = 8'd0;
            else if (jump_fwd)  nxt.hour = 8'd3;
            else if (repeat_hr) nxt.hour = 8'd1;
            else                nxt.hour = cal_q.hour + 8'd1;
        end
        if (c_hour) begin
            nxt.dow = (cal_q.dow >= 8'd7) ? 8'd1 : cal_q.dow + 8'd1;
            nxt.dom = c_day ? 8'd1 : cal_q.dom + 8'd1;
        end
        if (c_day)  nxt.mon  = c_mon ? 8'd1 : cal_q.mon + 8'd1;
        if (c_mon)  nxt.year = c_year ? 8'd0 : cal_q.year + 8'd1;
        if (c_year) nxt.cent = (cal_q.cent >= 8'd99) ? 8'd0 : cal_q.cent + 8'd1;
    end

    // Register update: software write wins, else a step applies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_q     <= '{sec: 8'd0, min: 8'd0, hour: 8'd0, dow: 8'd1,
                           dom: 8'd1, mon: 8'd1, year: 8'd0, cent: 8'd20};
            fell_q    <= 1'b0;
            stepped_o <= 1'b0;
        end else begin
            stepped_o <= advance;
            if (wr_en_i) begin
                case (wr_sel_i)
                    3'd0: cal_q.sec  <= wr_val_i;
                    3'd1: cal_q.min  <= wr_val_i;
                    3'd2: cal_q.hour <= wr_val_i;
                    3'd3: cal_q.dow  <= wr_val_i;
                    3'd4: cal_q.dom  <= wr_val_i;
                    3'd5: cal_q.mon  <= wr_val_i;
                    3'd6: cal_q.year <= wr_val_i;
                    default: cal_q.cent <= wr_val_i;
                endcase
            end else if (advance) begin
                cal_q <= nxt;
                if (c_hour)                 fell_q <= 1'b0;
                else if (c_min && repeat_hr) fell_q <= 1'b1;
            end
        end
    end

    // R1: a second below 58 steps by exactly one
    a_r1_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && cal_q.sec < 8'd58) |=> cal_o.sec == $past(cal_q.sec) + 8'd1);
    // R4: a step that does not wrap minutes leaves hour and date alone
    a_r4_no_early_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && cal_q.min < 8'd59) |=> ($stable(cal_o.hour) && $stable(cal_o.dom)
                                             && $stable(cal_o.dow)));
    // R9: a frozen step changes nothing
    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && hold_i && !wr_en_i) |=> $stable(cal_o));
    // R7: the spring shift lands on hour 3
    a_r7_spring: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && dst_en_i && cal_q.mon == FWD_M && cal_q.dom == FWD_D
         && cal_q.hour == 8'd1 && cal_q.min == 8'd59 && cal_q.sec == 8'd59)
        |=> cal_o.hour == 8'd3);
endmodule

// File: rtl/rtc_alarm.sv
// Alarm setting store, comparator and sticky pending flag with a selectable
// interrupt level. A match is only taken right after a counter step.
module rtc_alarm
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [1:0] wr_sel_i,
    input  logic [7:0] wr_val_i,
    input  cal_t       cal_i,
    input  logic       stepped_i,
    input  logic       clr_i,
    input  logic       irq_high_i,
    output logic [7:0] al_sec_o,
    output logic [7:0] al_min_o,
    output logic [7:0] al_hour_o,
    output logic [7:0] al_dom_o,
    output logic       match_o,
    output logic       irq_o
);
    logic flag_q;

    // Store alarm fields; day 0 at reset keeps the alarm disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            al_sec_o  <= 8'd0;
            al_min_o  <= 8'd0;
            al_hour_o <= 8'd0;
            al_dom_o  <= 8'd0;
        end else if (wr_en_i) begin
            case (wr_sel_i)
                2'd0: al_sec_o  <= wr_val_i;
                2'd1: al_min_o  <= wr_val_i;
                2'd2: al_hour_o <= wr_val_i;
                default: al_dom_o <= wr_val_i;
            endcase
        end
    end

    // Compare only in the cycle after a step so the pulse is one cycle wide.
    assign match_o = stepped_i && (cal_i.sec == al_sec_o) && (cal_i.min == al_min_o)
                     && (cal_i.hour == al_hour_o) && (cal_i.dom == al_dom_o);

    // Pending flag: a match sets it, a clear drops it, a match wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (match_o) flag_q <= 1'b1;
        else if (clr_i)   flag_q <= 1'b0;
    end

    assign irq_o = irq_high_i ? flag_q : !flag_q;

    // R11: a match always leaves the flag pending
    a_r11_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> flag_q);
    // R12: a pending flag drops only through a clear
    a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/rtc_core.sv
// Top of the calendar clock: prescaler, counter chain, alarm, mode register
// and the register port that translates BCD/binary and 12/24-hour on access.
module rtc_core
    import rtc_pkg::*;
#(
    parameter int PRESCALE = 32768,
    parameter int FWD_MON  = 3,
    parameter int FWD_DAY  = 10,
    parameter int BACK_MON = 11,
    parameter int BACK_DAY = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       wr_en,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       alarm_match_o,
    output logic       irq_o
);
    logic [MODE_W-1:0] mode_q;
    logic tick, stepped, is_hr, cal_wr, al_wr, mode_wr;
    logic [7:0] wval, field;
    logic [7:0] al_sec, al_min, al_hour, al_dom;
    cal_t cal;

    // Port value to stored binary 24-hour value.
    function automatic logic [7:0] dec_val(input logic [7:0] d, input logic hr,
                                           input logic bin, input logic h12);
        logic [7:0] raw, h;
        logic pm;
        pm  = hr && h12 && d[7];
        raw = (hr && h12) ? {1'b0, d[6:0]} : d;
        h   = bin ? raw : bin_of(raw);
        if (hr && h12) begin
            if (h == 8'd12) h = pm ? 8'd12 : 8'd0;
            else if (pm)    h = h + 8'd12;
        end
        return h;
    endfunction

    // Stored binary 24-hour value to port value.
    function automatic logic [7:0] enc_val(input logic [7:0] v, input logic hr,
                                           input logic bin, input logic h12);
        logic [7:0] h, o;
        logic pm;
        pm = 1'b0;
        h  = v;
        if (hr && h12) begin
            pm = v >= 8'd12;
            if (v == 8'd0)       h = 8'd12;
            else if (v > 8'd12)  h = v - 8'd12;
        end
        o = bin ? h : bcd_of(h);
        if (hr && h12) o = {pm, o[6:0]};
        return o;
    endfunction

    assign is_hr   = (addr == ADDR_HOUR) || (addr == ADDR_AHOUR);
    assign cal_wr  = wr_en && (addr[3] == 1'b0);
    assign al_wr   = wr_en && (addr[3:2] == 2'b10);
    assign mode_wr = wr_en && (addr == ADDR_MODE);
    assign wval    = dec_val(wdata, is_hr, mode_q[0], mode_q[1]);

    // Mode register; bit 7 of a write is a clear strobe, not stored.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= '0;
        else if (mode_wr) mode_q <= wdata[MODE_W-1:0];
    end

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_div (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .tick_o(tick));

    rtc_calendar #(.FWD_MON(FWD_MON), .FWD_DAY(FWD_DAY),
                   .BACK_MON(BACK_MON), .BACK_DAY(BACK_DAY)) u_cal (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .hold_i(mode_q[3]),
        .dst_en_i(mode_q[2]), .wr_en_i(cal_wr), .wr_sel_i(addr[2:0]),
        .wr_val_i(wval), .cal_o(cal), .stepped_o(stepped));

    rtc_alarm u_alm (
        .clk(clk), .rst_n(rst_n), .wr_en_i(al_wr), .wr_sel_i(addr[1:0]),
        .wr_val_i(wval), .cal_i(cal), .stepped_i(stepped),
        .clr_i(mode_wr && wdata[7]), .irq_high_i(mode_q[4]),
        .al_sec_o(al_sec), .al_min_o(al_min), .al_hour_o(al_hour),
        .al_dom_o(al_dom), .match_o(alarm_match_o), .irq_o(irq_o));

    // Read mux with translation into the current encoding.
    always_comb begin
        case (addr)
            ADDR_SEC:   field = cal.sec;
            ADDR_MIN:   field = cal.min;
            ADDR_HOUR:  field = cal.hour;
            ADDR_DOW:   field = cal.dow;
            ADDR_DOM:   field = cal.dom;
            ADDR_MON:   field = cal.mon;
            ADDR_YEAR:  field = cal.year;
            ADDR_CENT:  field = cal.cent;
            ADDR_ASEC:  field = al_sec;
            ADDR_AMIN:  field = al_min;
            ADDR_AHOUR: field = al_hour;
            ADDR_ADOM:  field = al_dom;
            default:    field = 8'd0;
        endcase
        if (addr == ADDR_MODE) rdata = {{(8-MODE_W){1'b0}}, mode_q};
        else                   rdata = enc_val(field, is_hr, mode_q[0], mode_q[1]);
    end
endmodule

// File: tb/rtc_core_tb.sv
`timescale 1ns/1ps
module rtc_core_tb;
    localparam int PS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic alarm_match_o, irq_o;
    int checks = 0;
    int fails = 0;
    int mcount = 0;
    bit done = 1'b0;

    rtc_core #(.PRESCALE(PS)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .alarm_match_o(alarm_match_o), .irq_o(irq_o));

    always #5 clk = ~clk;

    always @(posedge clk) if (rst_n && alarm_match_o) mcount++;

    task automatic chk(input string rq, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", rq, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic rchk(input string rq, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(rq, d, exp);
    endtask

    task automatic one_sec();
        @(negedge clk);
        ref_tick = 1'b1;
        repeat (PS) @(negedge clk);
        ref_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_dt(input logic [7:0] c, y, mo, d, h, mi, s);
        wr(4'h7, c); wr(4'h6, y); wr(4'h5, mo); wr(4'h4, d);
        wr(4'h2, h); wr(4'h1, mi); wr(4'h0, s);
    endtask

    task automatic t_reset();
        rchk("R1 reset sec", 4'h0, 8'h00);
        rchk("R1 reset hour", 4'h2, 8'h00);
        rchk("R1 reset dow", 4'h3, 8'h01);
        rchk("R1 reset dom", 4'h4, 8'h01);
        rchk("R1 reset month", 4'h5, 8'h01);
        rchk("R1 reset century", 4'h7, 8'h20);
        rchk("R1 reset mode", 4'hC, 8'h00);
        chk("R12 reset irq idle high", {7'd0, irq_o}, 8'h01);
    endtask

    task automatic t_count();
        repeat (3) one_sec();
        rchk("R1 three seconds", 4'h0, 8'h03);
        rchk("R1 minutes untouched", 4'h1, 8'h00);
    endtask

    task automatic t_rollover();
        wr(4'h3, 8'h07);
        set_dt(8'h20, 8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
        one_sec();
        rchk("R4 sec wrap", 4'h0, 8'h00);
        rchk("R4 min wrap", 4'h1, 8'h00);
        rchk("R4 hour wrap", 4'h2, 8'h00);
        rchk("R4 dow 7 to 1", 4'h3, 8'h01);
        rchk("R6 dom new year", 4'h4, 8'h01);
        rchk("R6 month new year", 4'h5, 8'h01);
        rchk("R6 year 99 to 0", 4'h6, 8'h00);
        rchk("R6 century carry", 4'h7, 8'h21);
    endtask

    task automatic t_leap();
        set_dt(8'h20, 8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        one_sec();
        rchk("R5 leap feb 29", 4'h4, 8'h29);
        wr(4'h2, 8'h23); wr(4'h1, 8'h59); wr(4'h0, 8'h59);
        one_sec();
        rchk("R5 leap after 29 dom", 4'h4, 8'h01);
        rchk("R5 leap after 29 month", 4'h5, 8'h03);
        set_dt(8'h21, 8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        one_sec();
        rchk("R5 century 21 not leap", 4'h5, 8'h03);
        set_dt(8'h20, 8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
        one_sec();
        rchk("R5 century 20 leap", 4'h4, 8'h29);
        set_dt(8'h20, 8'h25, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
        one_sec();
        rchk("R5 april 30 days", 4'h5, 8'h05);
    endtask

    task automatic t_binary();
        wr(4'hC, 8'h01);
        wr(4'h0, 8'h2D);
        rchk("R2 binary read", 4'h0, 8'h2D);
        wr(4'hC, 8'h00);
        rchk("R2 same value in BCD", 4'h0, 8'h45);
    endtask

    task automatic t_12h();
        wr(4'hC, 8'h02);
        wr(4'h2, 8'h12);
        wr(4'hC, 8'h00);
        rchk("R3 12 AM is 00", 4'h2, 8'h00);
        wr(4'hC, 8'h02);
        rchk("R3 midnight reads 12", 4'h2, 8'h12);
        wr(4'h2, 8'h81);
        wr(4'hC, 8'h00);
        rchk("R3 1 PM is 13", 4'h2, 8'h13);
        wr(4'hC, 8'h02);
        wr(4'h2, 8'h11); wr(4'h1, 8'h59); wr(4'h0, 8'h59);
        one_sec();
        rchk("R3 noon with PM", 4'h2, 8'h92);
        wr(4'hC, 8'h00);
        rchk("R3 noon in 24h", 4'h2, 8'h12);
    endtask

    task automatic t_spring();
        wr(4'hC, 8'h04);
        set_dt(8'h20, 8'h25, 8'h03, 8'h10, 8'h01, 8'h59, 8'h59);
        one_sec();
        rchk("R7 spring jump", 4'h2, 8'h03);
        rchk("R7 spring minutes", 4'h1, 8'h00);
        wr(4'hC, 8'h00);
        set_dt(8'h20, 8'h25, 8'h03, 8'h10, 8'h01, 8'h59, 8'h59);
        one_sec();
        rchk("R7 disabled no jump", 4'h2, 8'h02);
    endtask

    task automatic t_autumn();
        wr(4'hC, 8'h04);
        set_dt(8'h20, 8'h25, 8'h11, 8'h03, 8'h01, 8'h59, 8'h59);
        one_sec();
        rchk("R8 hour repeated", 4'h2, 8'h01);
        rchk("R8 minutes zero", 4'h1, 8'h00);
        wr(4'h1, 8'h59); wr(4'h0, 8'h59);
        one_sec();
        rchk("R8 only once", 4'h2, 8'h02);
        wr(4'hC, 8'h00);
    endtask

    task automatic t_inhibit();
        wr(4'hC, 8'h08);
        wr(4'h0, 8'h10);
        one_sec();
        rchk("R9 frozen", 4'h0, 8'h10);
        wr(4'hC, 8'h00);
        one_sec();
        rchk("R9 resumes", 4'h0, 8'h11);
    endtask

    task automatic t_range();
        wr(4'hC, 8'h01);
        wr(4'h2, 8'd5); wr(4'h1, 8'd2); wr(4'h0, 8'd75);
        one_sec();
        rchk("R10 sec 75 wraps", 4'h0, 8'd0);
        rchk("R10 sec carry", 4'h1, 8'd3);
        wr(4'h5, 8'd6); wr(4'h4, 8'd5);
        wr(4'h2, 8'd30); wr(4'h1, 8'd59); wr(4'h0, 8'd59);
        one_sec();
        rchk("R10 hour 30 wraps", 4'h2, 8'd0);
        rchk("R10 hour carry", 4'h4, 8'd6);
        wr(4'h6, 8'd10); wr(4'h5, 8'd13); wr(4'h4, 8'd31);
        wr(4'h2, 8'd23); wr(4'h1, 8'd59); wr(4'h0, 8'd59);
        one_sec();
        rchk("R10 month 13 wraps", 4'h5, 8'd1);
        rchk("R10 month carry", 4'h6, 8'd11);
        wr(4'hC, 8'h00);
    endtask

    task automatic t_alarm();
        int m0;
        set_dt(8'h20, 8'h25, 8'h06, 8'h15, 8'h08, 8'h30, 8'h00);
        wr(4'h8, 8'h02); wr(4'h9, 8'h30); wr(4'hA, 8'h08); wr(4'hB, 8'h15);
        rchk("R11 alarm hour readback", 4'hA, 8'h08);
        m0 = mcount;
        one_sec();
        chk("R11 no early match", 8'(mcount - m0), 8'd0);
        chk("R12 idle before match", {7'd0, irq_o}, 8'h01);
        one_sec();
        chk("R11 one match pulse", 8'(mcount - m0), 8'd1);
        chk("R12 active low pending", {7'd0, irq_o}, 8'h00);
        one_sec();
        chk("R11 no repeat pulse", 8'(mcount - m0), 8'd1);
        chk("R12 sticky", {7'd0, irq_o}, 8'h00);
        wr(4'hC, 8'h10);
        chk("R12 active high pending", {7'd0, irq_o}, 8'h01);
        wr(4'hC, 8'h90);
        chk("R12 cleared active high", {7'd0, irq_o}, 8'h00);
        rchk("R12 clear bit not stored", 4'hC, 8'h10);
        wr(4'hC, 8'h00);
        chk("R12 cleared active low", {7'd0, irq_o}, 8'h01);
    endtask

    initial begin
        #(10 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_rollover();
        t_leap();
        t_binary();
        t_12h();
        t_spring();
        t_autumn();
        t_inhibit();
        t_range();
        t_alarm();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule